// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block reads results from a 12-bit serial-output analog-to-digital converter. It divides the system clock to make a converter clock that runs without a break, inside conversions and between them. The block never switches to a second clock domain. It finds the converter clock's edges from its own divider, so all of its logic stays on the system clock.

Conversions are spaced by counting rising edges of the converter clock. A frame starts with a gap of three rising edges, during which the active-low convert strobe stays high. The strobe then drops and the block takes 13 serial bits, one on each of the next 13 rising edges, most significant bit first. The first of those bits is a leading bit and is thrown away. The strobe then returns high so the converter goes back to sampling.

Each 12-bit result is zero-extended to 16 bits. It appears on a parallel output together with a valid pulse that lasts one system clock. The serial input passes through a two-stage synchronizer, and the sampling point is delayed by the same amount so that the bit taken is the one present at the converter clock's rising edge.

Top module: `adc_serial_capture`

## Requirements
- R1: While reset (active low, synchronous) is asserted, the convert strobe is high, the converter clock is low, the valid pulse is low and the result output is zero.
- R2: The converter clock toggles every HALF_DIV system clocks with no pause, both inside and outside frames. Its first rise comes HALF_DIV clocks after reset is released.
- R3: In each frame the strobe stays high through three rising edges of the converter clock. It falls one system clock after the third of those edges and stays low through the capture.
- R4: One serial bit is taken for each of the 13 rising edges that follow the strobe's fall. Each bit is the value on the serial input at that edge, seen through the synchronizer. No bit is taken during the gap.
- R5: Bits are ordered most significant first: the earliest data bit received lands in result bit 11, and the last one lands in bit 0.
- R6: The leading bit received just after the strobe falls is discarded. Result bits 15 to 12 are always zero.
- R7: The valid pulse lasts exactly one system clock. It comes SYNC_STAGES+1 system clocks after the 13th capture edge, and the strobe returns high in that same clock.
- R8: Frames repeat without a break. Each frame spans 16 rising edges of the converter clock, so one result is produced per 32·HALF_DIV system clocks.
- R9: A reset in the middle of a frame abandons that frame without producing a result, and the next frame starts with the full three-edge gap.
- R10: The result output holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_sdata_i | input | 1 | Serial data from the converter (asynchronous to clk) |
| adc_sclk_o | output | 1 | Free-running converter clock |
| adc_conv_n_o | output | 1 | Active-low convert strobe |
| sample_o | output | 16 | Last completed result, zero-extended |
| sample_vld_o | output | 1 | One-clock pulse marking a new result |

## Verification
The embedded properties check the following on every cycle: the half period of the converter clock, that the strobe falls only right after a detected rising edge, that the strobe rises only together with the valid pulse, that the valid pulse lasts a single clock, that no bit is taken during the gap, and that the result changes only with valid. Only the bench's scenarios can show the rest. That covers the exact cycle on which the strobe falls and rises relative to the converter clock edges, the bit order, the discarding of the leading bit, and the frame rate. It also covers the recovery from a reset in mid-frame. To show these, a behavioural converter model shifts out known words and a closed-form timing model is compared with the ports on every clock.

// File: rtl/adc_cap_pkg.sv
// Package: shared types for the serial ADC capture controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package adc_cap_pkg;

    // Frame phase: waiting out the idle gap, or shifting bits in.
    typedef enum logic {
        PH_GAP   = 1'b0,
        PH_SHIFT = 1'b1
    } frame_ph_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Module: adc_sclk_gen
// Divides the system clock to produce a free-running converter clock and a
// one-cycle tick, in the system domain, during the first cycle the converter
// clock is high.
// Assumes: HALF_DIV >= 2; the converter clock output is a register, so the
// tick and the output rise together.
module adc_sclk_gen #(
    parameter int unsigned HALF_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic rise_tick_o
);

    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_q;
    logic          sclk_q;
    logic          rise_q;

    // Divider: count system clocks and toggle the converter clock each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (div_q == LAST) begin
                div_q  <= '0;
                sclk_q <= ~sclk_q;
                rise_q <= ~sclk_q;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk_o      = sclk_q;
    assign rise_tick_o = rise_q;

    // Checker state: age of the current converter clock level in system clocks.
    logic        chk_prev_q;
    int unsigned chk_age_q;

    // Checker: track the previous level and how long it has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_prev_q <= 1'b0;
            chk_age_q  <= 0;
        end else begin
            chk_prev_q <= sclk_q;
            chk_age_q  <= (sclk_q != chk_prev_q) ? 1 : chk_age_q + 1;
        end
    end

    // R2
    sclk_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q != chk_prev_q) |-> (chk_age_q == HALF_DIV));

    // R2
    rise_tick_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (sclk_q && !chk_prev_q));

endmodule

// File: rtl/adc_bit_sync.sv
// Module: adc_bit_sync
// Brings the asynchronous serial data into the system domain through a
// STAGES-deep flop chain and delays the capture tick by the same depth, so
// the tick leaving the block lines up with the bit that was present at the
// converter clock edge that raised it.
// Assumes: STAGES >= 2; the input changes only on falling converter clock
// edges, at least STAGES+1 system clocks away from a rising edge.
module adc_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    input  logic tick_i,
    output logic bit_o,
    output logic tick_o
);

    logic [STAGES-1:0] data_q;
    logic [STAGES-1:0] tick_q;

    // Synchronizer and matching tick delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            tick_q <= '0;
        end else begin
            data_q <= {data_q[STAGES-2:0], din_i};
            tick_q <= {tick_q[STAGES-2:0], tick_i};
        end
    end

    assign bit_o  = data_q[STAGES-1];
    assign tick_o = tick_q[STAGES-1];

endmodule

// File: rtl/adc_frame_ctrl.sv
// Module: adc_frame_ctrl
// Sequences one conversion frame: counts GAP_RISES rising converter clock
// ticks with the strobe high, drops the strobe, then collects
// LEAD_BITS+DATA_BITS synchronized bits MSB-first. On the last bit it raises
// the strobe, publishes the zero-extended data with a one-cycle valid and
// goes back to the gap.
// Assumes: DATA_BITS >= 3, WORD_BITS >= DATA_BITS, and bit ticks arrive only
// while shifting_o is high (the caller gates them).
module adc_frame_ctrl
    import adc_cap_pkg::*;
#(
    parameter int unsigned DATA_BITS = 12,
    parameter int unsigned LEAD_BITS = 1,
    parameter int unsigned GAP_RISES = 3,
    parameter int unsigned WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_tick_i,
    input  logic                 bit_i,
    input  logic                 bit_tick_i,
    output logic                 conv_n_o,
    output logic                 shifting_o,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_vld_o
);

    localparam int unsigned RAW_BITS = DATA_BITS + LEAD_BITS;
    localparam int unsigned BCW      = $clog2(RAW_BITS + 1);
    localparam int unsigned GCW      = $clog2(GAP_RISES + 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(RAW_BITS - 1);
    localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_RISES - 1);

    frame_ph_e              ph_q;
    logic [GCW-1:0]         gap_q;
    logic [BCW-1:0]         bit_cnt_q;
    logic [DATA_BITS-2:0]   hist_q;
    logic                   conv_n_q;
    logic [WORD_BITS-1:0]   word_q;
    logic                   vld_q;
    logic [DATA_BITS-1:0]   data_nxt;

    // Last DATA_BITS bits including the one arriving now; older bits fall off.
    assign data_nxt = {hist_q, bit_i};

    // Frame sequencer: gap counting, strobe, shifting and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_GAP;
            gap_q     <= '0;
            bit_cnt_q <= '0;
            hist_q    <= '0;
            conv_n_q  <= 1'b1;
            word_q    <= '0;
            vld_q     <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            case (ph_q)
                PH_GAP: begin
                    if (rise_tick_i) begin
                        if (gap_q == GAP_LAST) begin
                            gap_q     <= '0;
                            ph_q      <= PH_SHIFT;
                            conv_n_q  <= 1'b0;
                            bit_cnt_q <= '0;
                            hist_q    <= '0;
                        end else begin
                            gap_q <= gap_q + 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (bit_tick_i) begin
                        hist_q <= data_nxt[DATA_BITS-2:0];
                        if (bit_cnt_q == BIT_LAST) begin
                            word_q    <= WORD_BITS'(data_nxt);
                            vld_q     <= 1'b1;
                            conv_n_q  <= 1'b1;
                            ph_q      <= PH_GAP;
                            bit_cnt_q <= '0;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                default: ph_q <= PH_GAP;
            endcase
        end
    end

    assign conv_n_o   = conv_n_q;
    assign shifting_o = (ph_q == PH_SHIFT);
    assign word_o     = word_q;
    assign word_vld_o = vld_q;

    // R3
    conv_fall_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_q) |-> $past(rise_tick_i));

    // R4
    gap_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_GAP) |-> !bit_tick_i);

    // R4
    bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= BIT_LAST);

    // R7
    conv_rise_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n_q) |-> vld_q);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q != $past(word_q)) |-> vld_q);

endmodule

// File: rtl/adc_serial_capture.sv
// Module: adc_serial_capture (top)
// Serial ADC capture controller: free-running converter clock, edge-counted
// frame spacing, active-low convert strobe, synchronized MSB-first capture
// and a parallel result with a one-cycle valid.
// Assumes: HALF_DIV >= SYNC_STAGES + 2 so every capture completes inside
// the converter clock's high phase; the converter updates its data on
// falling converter clock edges.
module adc_serial_capture #(
    parameter int unsigned HALF_DIV    = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_BITS   = 12,
    parameter int unsigned LEAD_BITS   = 1,
    parameter int unsigned GAP_RISES   = 3,
    parameter int unsigned WORD_BITS   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adc_sdata_i,
    output logic                 adc_sclk_o,
    output logic                 adc_conv_n_o,
    output logic [WORD_BITS-1:0] sample_o,
    output logic                 sample_vld_o
);

    logic rise_tick;
    logic shifting;
    logic cap_tick_raw;
    logic cap_tick;
    logic cap_bit;

    // Converter clock and rising-edge tick.
    adc_sclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_sclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_o      (adc_sclk_o),
        .rise_tick_o (rise_tick)
    );

    // Only rising edges seen while shifting request a capture.
    assign cap_tick_raw = rise_tick & shifting;

    // Data synchronizer with aligned capture tick.
    adc_bit_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (adc_sdata_i),
        .tick_i (cap_tick_raw),
        .bit_o  (cap_bit),
        .tick_o (cap_tick)
    );

    // Frame sequencing and result assembly.
    adc_frame_ctrl #(
        .DATA_BITS (DATA_BITS),
        .LEAD_BITS (LEAD_BITS),
        .GAP_RISES (GAP_RISES),
        .WORD_BITS (WORD_BITS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_tick_i (rise_tick),
        .bit_i       (cap_bit),
        .bit_tick_i  (cap_tick),
        .conv_n_o    (adc_conv_n_o),
        .shifting_o  (shifting),
        .word_o      (sample_o),
        .word_vld_o  (sample_vld_o)
    );

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o[WORD_BITS-1:DATA_BITS] == '0);

    // R2
    sclk_low_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !adc_sclk_o);

endmodule

// File: tb/tb_adc_serial_capture.sv
module tb_adc_serial_capture;

    localparam int H    = 6;
    localparam int STG  = 2;
    localparam int P    = 2 * H;
    localparam int FR   = 16;
    localparam int RAW  = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        sclk;
    logic        conv_n;
    logic [15:0] sample;
    logic        vld;

    always #10 clk = ~clk;

    adc_serial_capture #(
        .HALF_DIV    (H),
        .SYNC_STAGES (STG)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_sdata_i  (sdata),
        .adc_sclk_o   (sclk),
        .adc_conv_n_o (conv_n),
        .sample_o     (sample),
        .sample_vld_o (vld)
    );

    int total = 0;
    int bad   = 0;
    int n     = 0;
    int valids = 0;
    logic [15:0] exp_word = '0;
    logic [12:0] exp_q[$];
    logic [12:0] stim_q[$];
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            if (bad < 30) $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural converter: takes a word when the strobe falls, drives one bit per falling sclk.
    logic        prev_conv = 1'b1;
    logic        prev_sclk = 1'b0;
    logic [12:0] cur = '0;
    int          idx = 0;
    always @(negedge clk) begin
        if (conv_n) begin
            idx = 0;
        end else if (prev_conv) begin
            if (stim_q.size() > 0) cur = stim_q.pop_front();
            else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cur = lfsr[12:0];
            end
            exp_q.push_back(cur);
            idx = 0;
        end
        if (!conv_n && prev_sclk && !sclk && idx < RAW) begin
            sdata = cur[RAW-1-idx];
            idx++;
        end
        prev_conv = conv_n;
        prev_sclk = sclk;
    end

    // Reference timing model compared with the ports after every clock.
    int  ri, off, j;
    bit  e_sclk, e_conv, e_vld;
    string ctag;
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            n = 0;
            exp_word = '0;
            exp_q.delete();
            // R1 (and R9 when applied mid-frame)
            check(conv_n == 1'b1, "R1 R9 strobe in reset", conv_n, 1);
            check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
            check(vld == 1'b0, "R1 valid in reset", vld, 0);
            check(sample == 16'h0, "R1 result in reset", sample, 0);
        end else begin
            n++;
            e_sclk = ((n / H) % 2) == 1;
            e_conv = 1'b1;
            e_vld  = 1'b0;
            ctag   = "R3 gap strobe";
            if (n >= H) begin
                ri  = (n - H) / P + 1;
                off = (n - H) % P;
                j   = (ri - 1) % FR + 1;
                if ((j == 3 && off >= 1) || (j >= 4 && j <= 15) || (j == 16 && off <= STG))
                    e_conv = 1'b0;
                if (j == 16 && off == STG + 1) e_vld = 1'b1;
                if (j >= 16) ctag = "R7 strobe release";
            end
            check(sclk == e_sclk, "R2 sclk", sclk, e_sclk);
            check(conv_n == e_conv, ctag, conv_n, e_conv);
            check(vld == e_vld, "R7 R8 valid timing", vld, e_vld);
            if (vld) begin
                valids++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 no word pending", sample, 0);
                end else begin
                    exp_word = {4'h0, exp_q.pop_front() & 13'h0FFF};
                    // R4 R5 R6: MSB-first, leading bit dropped, zero-extended
                    check(sample == exp_word, "R4 R5 R6 result", sample, exp_word);
                end
            end else begin
                check(sample == exp_word, "R10 result hold", sample, exp_word);
            end
        end
    end

    int base;
    initial begin
        // Corner words: leading bit set/clear, extremes, single bits, alternating.
        stim_q.push_back(13'h1FFF);
        stim_q.push_back(13'h0000);
        stim_q.push_back(13'h1000);
        stim_q.push_back(13'h0800);
        stim_q.push_back(13'h0001);
        stim_q.push_back(13'h0AAA);
        stim_q.push_back(13'h1555);
        stim_q.push_back(13'h0FFF);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (valids < 20) @(negedge clk);
        // R9: reset in the middle of a capture
        while (conv_n) @(negedge clk);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        stim_q.push_back(13'h1ABC);
        stim_q.push_back(13'h0123);
        rst_n = 1'b1;
        base = valids;
        repeat (192 * H) @(negedge clk);
        // R8: six frames in 6*32*HALF_DIV clocks after reset
        check((valids - base) == 6, "R8 R9 frame count", valids - base, 6);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", valids);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule